// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block runs the bus cycle that a processor uses to learn which exception vector belongs to an interrupt it has already decided to take. A start strobe begins the cycle. The block captures the priority level from the interrupt lines at that moment, and it keeps using that captured level even if the lines change later.

The cycle has two steps. In the first, the block presents an acknowledge address with all strobes idle. In the second, it asserts the address strobe and the low-byte data strobe as a read. It holds them until one of three terminating inputs arrives:

- **Bus error** gives the fixed spurious vector.
- **Autovector request** gives a vector derived from the captured level.
- **Data acknowledge** takes the vector from the data bus.

The block then releases the bus. It registers the vector number and the byte address of that vector's table entry, and pulses a done flag. The surrounding sequencer uses these outputs to fetch the handler address.

Top module: `iack_resolver`

## Requirements
- R1: After synchronous active-high reset the block is idle: address strobe, both data strobes, read line and done are low; function code is 000; address is zero.
- R2: A start in idle captures the 3-bit level on the interrupt lines. The address uses that captured value for the whole cycle, whatever the interrupt lines do afterwards.
- R3: The function-code output is 111 in both steps of the cycle and 000 when idle.
- R4: During the cycle, address bits 3:1 carry the captured level, bit 0 is 1, and all higher bits are 0. When idle the address is zero.
- R5: The first step lasts exactly one clock, with all strobes low and the read line high. In the second step, the address strobe and the low-byte data strobe are high, the high-byte data strobe is low and the read line is high. This holds until a terminating input is seen.
- R6: Ending with bus error gives vector number 24.
- R7: Ending with the autovector request gives vector number 24 plus the captured level.
- R8: Ending with data acknowledge gives vector number equal to data bus bits 7:0, sampled on the terminating clock.
- R9: When several terminating inputs are high together, bus error beats autovector, and autovector beats data acknowledge.
- R10: The vector address output equals the vector number times 4, zero-extended to the address width.
- R11: On the clock after a terminating input, the strobes, the read line and the function code return to idle and done is high for exactly one cycle. The vector outputs hold until the next cycle completes.
- R12: A start asserted while a cycle is in progress is ignored: it neither restarts the cycle nor changes the captured level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an acknowledge cycle |
| ipl_i | input | 3 | Interrupt priority level from the bus |
| dtack_i | input | 1 | Data acknowledge, vector on the data bus |
| autovec_i | input | 1 | Peripheral asks for an autovector |
| berr_i | input | 1 | Bus error, spurious interrupt |
| data_i | input | 8 | Data bus |
| addr_o | output | 24 | Acknowledge address |
| fc_o | output | 3 | Function code lines |
| as_o | output | 1 | Address strobe (active high) |
| ds_hi_o | output | 1 | High-byte data strobe (active high) |
| ds_lo_o | output | 1 | Low-byte data strobe (active high) |
| rd_o | output | 1 | Read indication, high during the cycle |
| vec_num_o | output | 8 | Resolved vector number |
| vec_addr_o | output | 24 | Vector-table byte address |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each of the three terminators is driven alone, so the three vector sources are told apart. The bench then drives every combination of two or three terminators together; an error in the priority order shows up as the wrong number. Levels from 0 to 7 and data bytes at 0x00, 0xFF and random values separate the autovector arithmetic from the data path. Two more stimuli run during a cycle: the interrupt lines are changed and start is pulsed, so that a recapture or a restart shows up in the address or the function code. Terminator delays of zero to several cycles confirm that the strobes are held.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int unsigned LVL_W       = 3;
  localparam int unsigned SPURIOUS_NO = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_PRESENT, ST_STROBE} iack_state_e;

  // Autovector number for a level: base of the autovector block plus level.
  function automatic logic [7:0] autovec_no(input logic [LVL_W-1:0] lvl);
    return 8'(SPURIOUS_NO) + 8'(lvl);
  endfunction

  // Table byte address: four bytes per entry.
  function automatic logic [31:0] table_addr(input logic [7:0] vec);
    return {22'd0, vec, 2'b00};
  endfunction
endpackage

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic             term_i,
  output iack_state_e      state_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             finish_o
);
  iack_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic             accept;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign finish_o = (state_q == ST_STROBE) && term_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:    if (accept) state_q <= ST_PRESENT;
        ST_PRESENT: state_q <= ST_STROBE;
        ST_STROBE:  if (term_i) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
      if (accept) lvl_q <= ipl_i;
    end
  end

  assign state_o = state_q;
  assign lvl_o   = lvl_q;

  a_r5_present_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRESENT) |=> (state_q == ST_STROBE));
  a_r12_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (state_q != ST_PRESENT));
  a_r2_level_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(lvl_q));
endmodule

// File: rtl/iack_vector_sel.sv
module iack_vector_sel
  import iack_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic             berr_i,
  input  logic             autovec_i,
  input  logic             dtack_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             term_o,
  output logic [VEC_W-1:0] vec_o
);
  assign term_o = berr_i | autovec_i | dtack_i;

  always_comb begin
    if (berr_i)         vec_o = VEC_W'(SPURIOUS_NO);
    else if (autovec_i) vec_o = VEC_W'(autovec_no(lvl_i));
    else                vec_o = data_i;
  end
endmodule

// File: rtl/iack_resolver.sv
module iack_resolver
  import iack_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        ipl_i,
  input  logic              dtack_i,
  input  logic              autovec_i,
  input  logic              berr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        fc_o,
  output logic              as_o,
  output logic              ds_hi_o,
  output logic              ds_lo_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              done_o
);
  localparam int unsigned VEC_W = DATA_W;

  iack_state_e      state;
  logic [LVL_W-1:0] lvl;
  logic             term, finish, busy, strobing;
  logic [VEC_W-1:0] vec_next, vec_q;
  logic             done_q;

  iack_seq u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .ipl_i(ipl_i),
    .term_i(term), .state_o(state), .lvl_o(lvl), .finish_o(finish)
  );

  iack_vector_sel #(.VEC_W(VEC_W)) u_sel (
    .berr_i(berr_i), .autovec_i(autovec_i), .dtack_i(dtack_i),
    .data_i(data_i), .lvl_i(lvl), .term_o(term), .vec_o(vec_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) vec_q <= vec_next;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign strobing = (state == ST_STROBE);

  assign fc_o       = busy ? 3'b111 : 3'b000;
  assign addr_o     = busy ? ADDR_W'({lvl, 1'b1}) : '0;
  assign as_o       = strobing;
  assign ds_lo_o    = strobing;
  assign ds_hi_o    = 1'b0;
  assign rd_o       = busy;
  assign vec_num_o  = vec_q;
  assign vec_addr_o = ADDR_W'(table_addr(8'(vec_q)));
  assign done_o     = done_q;

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    finish |=> (!as_o && !ds_lo_o && done_o));
  a_r3_fc_marks_cycle: assert property (@(posedge clk) disable iff (rst)
    as_o |-> (fc_o == 3'b111));
  a_r6_spurious: assert property (@(posedge clk) disable iff (rst)
    (finish && berr_i) |=> (vec_num_o == VEC_W'(SPURIOUS_NO)));
  a_r10_addr_scaled: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (vec_addr_o[1:0] == 2'b00));
endmodule

// File: tb/test_iack_resolver.sv
module test_iack_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  ipl_i = '0;
  logic        dtack_i = 1'b0, autovec_i = 1'b0, berr_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [23:0] addr_o, vec_addr_o;
  logic [2:0]  fc_o;
  logic        as_o, ds_hi_o, ds_lo_o, rd_o, done_o;
  logic [7:0]  vec_num_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  iack_resolver i_iack_resolver (
    .clk(clk), .rst(rst), .start_i(start_i), .ipl_i(ipl_i),
    .dtack_i(dtack_i), .autovec_i(autovec_i), .berr_i(berr_i), .data_i(data_i),
    .addr_o(addr_o), .fc_o(fc_o), .as_o(as_o), .ds_hi_o(ds_hi_o), .ds_lo_o(ds_lo_o),
    .rd_o(rd_o), .vec_num_o(vec_num_o), .vec_addr_o(vec_addr_o), .done_o(done_o)
  );

  function automatic int exp_vec(bit be, bit av, int lvl, int d);
    if (be) return 24;
    if (av) return 24 + lvl;
    return d;
  endfunction

  function automatic int exp_addr(int lvl);
    return lvl * 2 + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic eq(string req, string what, int act, int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // One full acknowledge cycle.
  task automatic run_cycle(int lvl, bit be, bit av, bit dt, int d, int wait_n, bit poke);
    int ev;
    int prev_vec;
    ev = exp_vec(be, av, lvl, d);
    @(negedge clk);
    start_i = 1'b1; ipl_i = 3'(lvl);
    @(negedge clk);  // first step
    start_i = poke; ipl_i = 3'(~lvl);
    eq("R3", "fc step1", fc_o, 7);
    eq("R4", "addr step1", addr_o, exp_addr(lvl));
    eq("R5", "strobes step1", {as_o, ds_hi_o, ds_lo_o}, 0);
    eq("R5", "rd step1", rd_o, 1);
    @(negedge clk);  // second step
    eq("R5", "strobes step2", {as_o, ds_hi_o, ds_lo_o}, 5);
    eq("R2", "addr keeps level", addr_o, exp_addr(lvl));
    eq("R3", "fc step2", fc_o, 7);
    for (int k = 0; k < wait_n; k++) begin
      ipl_i = 3'($urandom);
      @(negedge clk);
      eq("R5", "strobes held", {as_o, ds_hi_o, ds_lo_o}, 5);
      eq("R12", "addr after busy start", addr_o, exp_addr(lvl));
      eq("R11", "no early done", done_o, 0);
    end
    start_i = 1'b0;
    berr_i = be; autovec_i = av; dtack_i = dt; data_i = 8'(d);
    @(negedge clk);
    berr_i = 1'b0; autovec_i = 1'b0; dtack_i = 1'b0; data_i = 8'($urandom);
    eq("R11", "done", done_o, 1);
    eq("R11", "strobes released", {as_o, ds_hi_o, ds_lo_o, rd_o}, 0);
    eq("R3", "fc idle", fc_o, 0);
    eq("R4", "addr idle", addr_o, 0);
    if (be) eq("R6", "spurious vec", vec_num_o, ev);
    else if (av) eq("R7", "autovec", vec_num_o, ev);
    else eq("R8", "data vec", vec_num_o, ev);
    if (be + av + dt > 1) eq("R9", "priority vec", vec_num_o, ev);
    eq("R10", "vec addr", vec_addr_o, ev * 4);
    prev_vec = vec_num_o;
    @(negedge clk);
    eq("R11", "done one cycle", done_o, 0);
    eq("R11", "vec held", vec_num_o, prev_vec);
    eq("R12", "no restart", fc_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    eq("R1", "reset strobes", {as_o, ds_hi_o, ds_lo_o, rd_o, done_o}, 0);
    eq("R1", "reset fc", fc_o, 0);
    eq("R1", "reset addr", addr_o, 0);
    // Directed corners
    run_cycle(3, 1, 0, 0, 8'h55, 0, 0);   // R6
    run_cycle(7, 0, 1, 0, 8'h12, 1, 0);   // R7
    run_cycle(0, 0, 1, 0, 8'h12, 0, 0);   // R7 level 0
    run_cycle(5, 0, 0, 1, 8'hFF, 2, 1);   // R8, R12
    run_cycle(2, 0, 0, 1, 8'h00, 0, 0);   // R8
    run_cycle(6, 1, 1, 1, 8'h40, 0, 0);   // R9
    run_cycle(4, 0, 1, 1, 8'h40, 3, 1);   // R9
    run_cycle(1, 1, 0, 1, 8'h40, 0, 0);   // R9
    run_cycle(6, 1, 1, 0, 8'h40, 0, 0);   // R9
    // Random
    for (int n = 0; n < 40; n++) begin
      int t;
      t = 1 + ($urandom % 7);
      run_cycle($urandom % 8, t[2], t[1], t[0], $urandom % 256, $urandom % 4, 1'($urandom));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule